// File: doc/BRIEF.md
# Two-Wire Controller Register Handshake

This block is the software-facing register layer of a two-wire (I2C-compatible) controller. Software reaches it over a simple one-cycle register port. It holds a control register, a bit-rate divisor register and a one-byte data register. Towards the serial engine it drives the enable, start, stop and acknowledge requests and the transmit byte. It also produces a half-period SCL tick from the divisor.

The engine and software work through a completion flag. When the engine finishes an operation, it raises the flag. While the flag is set, the block asks the bus side to hold SCL low and the tick divider stops. Software then services the data register and releases the bus by writing a one to the flag bit. A data-register write made while the flag is clear is refused, and the block records this in a read-only collision bit. The block has no bus-timeout detection. A stuck bus during slave operation stays stuck until software disables the controller.

Top module: `twi_hs_top`

## Requirements
- R1: After reset, all three registers read 0x00, and irq, scl_hold, scl_tick, eng_en, eng_start and eng_stop are all 0.
- R2: When enable (control bit 2) is 1 and eng_done is pulsed, the flag (control bit 7) reads 1 from the next cycle. If software writes a one to bit 7 in the same cycle, the set wins.
- R3: The flag clears only when software writes the control register (wr_sel=0) with bit 7 = 1. A write with bit 7 = 0, or irq being serviced, leaves it set.
- R4: irq is 1 exactly when the flag, interrupt enable (control bit 0) and glb_irq_en are all 1.
- R5: scl_hold is 1 exactly when the flag and enable are both 1. While it is 1, scl_tick stays 0 and the divider does not advance.
- R6: A data-register write (wr_sel=2) made while the flag is set stores the byte and clears the collision bit (control bit 3). Made while the flag is clear, it leaves the byte unchanged and sets the collision bit. Control-register writes never change the collision bit.
- R7: With enable 1 and no hold, scl_tick pulses once every 16 + 2 × rate cycles, where rate is the bit-rate register (wr_sel=1). With enable 0, scl_tick stays 0.
- R8: While enable is 0, start (bit 5) and stop (bit 4) read 0 and eng_en is 0. This includes a write that clears enable and sets start or stop in the same cycle. The other registers stay readable.
- R9: Stop clears one cycle after eng_stop_done unless software writes the control register in that cycle. Start stays set until software writes it to 0.
- R10: Control bit 1 always reads 0, and wr_sel=3 reads 0x00. A pulse on eng_rx_load while enabled loads eng_rx_byte into the data register unless a software data write is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 rate, 2 data |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 2 | Read target, same coding, 3 reads zero |
| rd_data | output | 8 | Read byte of the selected register |
| glb_irq_en | input | 1 | Global interrupt enable |
| eng_done | input | 1 | Engine finished an operation |
| eng_stop_done | input | 1 | Engine has driven the stop condition |
| eng_rx_load | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_en | output | 1 | Controller enabled; 0 releases SCL and SDA |
| eng_start | output | 1 | Start request |
| eng_stop | output | 1 | Stop request |
| eng_ack | output | 1 | Acknowledge enable |
| eng_tx_byte | output | 8 | Data register contents |
| scl_hold | output | 1 | Keep SCL low (stretch) |
| scl_tick | output | 1 | SCL half-period tick |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land in the same cycle: a completion arriving from the engine and software's write-one-to-clear of the flag. Both are provoked together, on purpose in a directed case and at random during a mixed stream. Afterwards the flag must read 1, SCL must stay held and irq must follow the gate. A data write in the cycle the flag is being set is also judged against the flag value before that edge, so it counts as a collision.

// File: rtl/twi_hs_pkg.sv
package twi_hs_pkg;
  localparam int DW = 8;
  localparam int SW = 2;

  localparam logic [SW-1:0] SEL_CTRL = 2'd0;
  localparam logic [SW-1:0] SEL_RATE = 2'd1;
  localparam logic [SW-1:0] SEL_DATA = 2'd2;

  localparam int B_FLAG = 7;
  localparam int B_ACK  = 6;
  localparam int B_STA  = 5;
  localparam int B_STO  = 4;
  localparam int B_WCOL = 3;
  localparam int B_EN   = 2;
  localparam int B_IE   = 0;

  typedef struct packed {
    logic flag;
    logic ack;
    logic sta;
    logic sto;
    logic wcol;
    logic en;
    logic ie;
  } ctrl_t;

  function automatic logic [DW-1:0] ctrl_pack(input ctrl_t c);
    logic [DW-1:0] b;
    b = '0;
    b[B_FLAG] = c.flag;
    b[B_ACK]  = c.ack;
    b[B_STA]  = c.sta;
    b[B_STO]  = c.sto;
    b[B_WCOL] = c.wcol;
    b[B_EN]   = c.en;
    b[B_IE]   = c.ie;
    return b;
  endfunction
endpackage

// File: rtl/twi_hs_rstsync.sv
module twi_hs_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = sh_q[STAGES-1];
endmodule

// File: rtl/twi_hs_ctrl.sv
module twi_hs_ctrl
  import twi_hs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          data_wr,
  input  logic          eng_done,
  input  logic          eng_stop_done,
  output ctrl_t         ctl_q
);
  ctrl_t ctl_d;
  logic  en_next;

  always_comb begin
    ctl_d   = ctl_q;
    en_next = wr_ctrl ? wdata[B_EN] : ctl_q.en;
    ctl_d.en = en_next;
    if (wr_ctrl) begin
      ctl_d.ack = wdata[B_ACK];
      ctl_d.ie  = wdata[B_IE];
      ctl_d.sta = wdata[B_STA];
      ctl_d.sto = wdata[B_STO];
    end else if (eng_stop_done) begin
      ctl_d.sto = 1'b0;
    end
    if (!en_next) begin
      ctl_d.sta = 1'b0;
      ctl_d.sto = 1'b0;
    end
    if (ctl_q.en && eng_done)            ctl_d.flag = 1'b1;
    else if (wr_ctrl && wdata[B_FLAG])   ctl_d.flag = 1'b0;
    if (data_wr) ctl_d.wcol = ~ctl_q.flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/twi_hs_data.sv
module twi_hs_data #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_wr,
  input  logic         flag,
  input  logic         en,
  input  logic [W-1:0] wdata,
  input  logic         rx_load,
  input  logic [W-1:0] rx_byte,
  output logic [W-1:0] data_q
);
  logic [W-1:0] data_d;
  logic         sw_take;
  logic         hw_take;
  logic         load_en;

  assign sw_take = data_wr && flag;
  assign hw_take = rx_load && en && !sw_take;
  assign load_en = sw_take || hw_take;

  always_comb begin
    data_d = data_q;
    if (sw_take)      data_d = wdata;
    else if (hw_take) data_d = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= data_d;
  end
endmodule

// File: rtl/twi_hs_tick.sv
module twi_hs_tick #(
  parameter int W    = 8,
  parameter int BASE = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rate_wr,
  input  logic [W-1:0] wdata,
  input  logic         en,
  input  logic         hold,
  output logic [W-1:0] rate_q,
  output logic         tick
);
  localparam int MAXLIM = BASE + 2 * ((1 << W) - 1);
  localparam int CW     = $clog2(MAXLIM + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim_m1;
  logic          run;
  logic          wrap;

  assign lim_m1 = CW'(BASE - 1) + (CW'(rate_q) << 1);
  assign run    = en && !hold;
  assign wrap   = cnt_q >= lim_m1;
  assign tick   = run && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)      cnt_d = '0;
    else if (run) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rate_q <= '0;
    else if (rate_wr) rate_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/twi_hs_top.sv
module twi_hs_top
  import twi_hs_pkg::*;
#(
  parameter int TICK_BASE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [SW-1:0] rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          glb_irq_en,
  input  logic          eng_done,
  input  logic          eng_stop_done,
  input  logic          eng_rx_load,
  input  logic [DW-1:0] eng_rx_byte,
  output logic          eng_en,
  output logic          eng_start,
  output logic          eng_stop,
  output logic          eng_ack,
  output logic [DW-1:0] eng_tx_byte,
  output logic          scl_hold,
  output logic          scl_tick,
  output logic          irq
);
  logic          rst_q;
  ctrl_t         ctl_q;
  logic [DW-1:0] rate_q;
  logic [DW-1:0] data_q;
  logic          wr_ctrl, wr_rate, wr_dat;

  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
  assign wr_rate = wr_en && (wr_sel == SEL_RATE);
  assign wr_dat  = wr_en && (wr_sel == SEL_DATA);

  twi_hs_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  twi_hs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_q), .wr_ctrl(wr_ctrl), .wdata(wr_data),
    .data_wr(wr_dat), .eng_done(eng_done), .eng_stop_done(eng_stop_done),
    .ctl_q(ctl_q)
  );

  twi_hs_data #(.W(DW)) u_data (
    .clk(clk), .rst_n(rst_q), .data_wr(wr_dat), .flag(ctl_q.flag),
    .en(ctl_q.en), .wdata(wr_data), .rx_load(eng_rx_load),
    .rx_byte(eng_rx_byte), .data_q(data_q)
  );

  twi_hs_tick #(.W(DW), .BASE(TICK_BASE)) u_tick (
    .clk(clk), .rst_n(rst_q), .rate_wr(wr_rate), .wdata(wr_data),
    .en(ctl_q.en), .hold(scl_hold), .rate_q(rate_q), .tick(scl_tick)
  );

  always_comb begin
    case (rd_sel)
      SEL_CTRL: rd_data = ctrl_pack(ctl_q);
      SEL_RATE: rd_data = rate_q;
      SEL_DATA: rd_data = data_q;
      default:  rd_data = '0;
    endcase
  end

  assign eng_en      = ctl_q.en;
  assign eng_start   = ctl_q.sta;
  assign eng_stop    = ctl_q.sto;
  assign eng_ack     = ctl_q.ack;
  assign eng_tx_byte = data_q;
  assign scl_hold    = ctl_q.flag && ctl_q.en;
  assign irq         = ctl_q.flag && ctl_q.ie && glb_irq_en;
endmodule

// File: rtl/twi_hs_chk.sv
module twi_hs_chk
  import twi_hs_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input ctrl_t         ctl,
  input logic          wr_en,
  input logic [SW-1:0] wr_sel,
  input logic [DW-1:0] wr_data,
  input logic          eng_done,
  input logic          eng_stop_done,
  input logic          eng_rx_load,
  input logic [DW-1:0] tx_byte,
  input logic          glb_irq_en,
  input logic          irq,
  input logic          scl_hold,
  input logic          scl_tick
);
  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en && eng_done) |=> ctl.flag);

  p_flag_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.flag && !(wr_en && wr_sel == SEL_CTRL && wr_data[B_FLAG])) |=> ctl.flag);

  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (glb_irq_en && ctl.flag && ctl.ie));

  p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> !scl_tick);

  p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DATA && !ctl.flag && !eng_rx_load)
      |=> (ctl.wcol && tx_byte == $past(tx_byte)));

  p_idle_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |-> !scl_tick);

  p_off_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |-> (!ctl.sta && !ctl.sto));

  p_stop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sto && eng_stop_done && !(wr_en && wr_sel == SEL_CTRL)) |=> !ctl.sto);
endmodule

bind twi_hs_top twi_hs_chk u_chk (
  .clk(clk), .rst_n(rst_q), .ctl(ctl_q), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .eng_done(eng_done), .eng_stop_done(eng_stop_done),
  .eng_rx_load(eng_rx_load), .tx_byte(eng_tx_byte), .glb_irq_en(glb_irq_en),
  .irq(irq), .scl_hold(scl_hold), .scl_tick(scl_tick)
);

// File: tb/tb_twi_hs_top.sv
module tb_twi_hs_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, glb_irq_en, eng_done, eng_stop_done, eng_rx_load;
  logic [1:0] wr_sel, rd_sel;
  logic [7:0] wr_data, eng_rx_byte, rd_data, eng_tx_byte;
  logic       eng_en, eng_start, eng_stop, eng_ack, scl_hold, scl_tick, irq;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  logic m_flag, m_ack, m_sta, m_sto, m_wcol, m_en, m_ie;
  logic [7:0] m_rate, m_data;

  always #2.5 clk = ~clk;

  twi_hs_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .glb_irq_en(glb_irq_en),
    .eng_done(eng_done), .eng_stop_done(eng_stop_done), .eng_rx_load(eng_rx_load),
    .eng_rx_byte(eng_rx_byte), .eng_en(eng_en), .eng_start(eng_start),
    .eng_stop(eng_stop), .eng_ack(eng_ack), .eng_tx_byte(eng_tx_byte),
    .scl_hold(scl_hold), .scl_tick(scl_tick), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctrl();
    return {m_flag, m_ack, m_sta, m_sto, m_wcol, m_en, 1'b0, m_ie};
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] s);
    case (s)
      2'd0: return exp_ctrl();
      2'd1: return m_rate;
      2'd2: return m_data;
      default: return 8'h00;
    endcase
  endfunction

  // model update from the requirements, using state before the edge
  task automatic model_step();
    logic w0, w1, w2, en_n, take;
    w0 = wr_en && wr_sel == 2'd0;
    w1 = wr_en && wr_sel == 2'd1;
    w2 = wr_en && wr_sel == 2'd2;
    en_n = w0 ? wr_data[2] : m_en;
    take = w2 && m_flag;
    if (w2) m_wcol = !m_flag;                          // R6
    if (take) m_data = wr_data;
    else if (eng_rx_load && m_en) m_data = eng_rx_byte; // R10
    if (w1) m_rate = wr_data;
    if (m_en && eng_done) m_flag = 1'b1;                // R2
    else if (w0 && wr_data[7]) m_flag = 1'b0;           // R3
    if (w0) begin
      m_ack = wr_data[6]; m_ie = wr_data[0];
      m_sta = wr_data[5]; m_sto = wr_data[4];
    end else if (eng_stop_done) m_sto = 1'b0;           // R9
    m_en = en_n;
    if (!en_n) begin m_sta = 1'b0; m_sto = 1'b0; end    // R8
  endtask

  task automatic idle_in();
    wr_en = 0; wr_sel = 0; wr_data = 0; eng_done = 0; eng_stop_done = 0;
    eng_rx_load = 0; eng_rx_byte = 0;
  endtask

  // one cycle: inputs already driven; edge; compare at negedge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(rd_sel == 0 ? "R3 ctrl read" : rd_sel == 1 ? "R7 rate read" :
          rd_sel == 2 ? "R6 data read" : "R10 null read", rd_data, exp_read(rd_sel));
    check("R4 irq", irq, m_flag && m_ie && glb_irq_en);
    check("R5 hold", scl_hold, m_flag && m_en);
    check("R9 start/stop", {eng_start, eng_stop}, {m_sta, m_sto});
    check("R8 eng_en", eng_en, m_en);
    check("R6 tx byte", eng_tx_byte, m_data);
    if (!m_en) check("R7 no tick when off", scl_tick, 1'b0);
    if (m_flag && m_en) check("R5 no tick in hold", scl_tick, 1'b0);
    idle_in();
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    cyc();
  endtask

  // cycles between two consecutive ticks while idle
  task automatic tick_gap(output int gap);
    int first;
    first = -1;
    gap = -1;
    for (int i = 0; i < 2000; i++) begin
      cyc();
      if (scl_tick) begin
        if (first >= 0) begin gap = i - first; return; end
        first = i;
      end
    end
  endtask

  initial begin
    int gap;
    int seen;
    logic [31:0] seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    idle_in();
    rd_sel = 0; glb_irq_en = 0;
    m_flag = 0; m_ack = 0; m_sta = 0; m_sto = 0; m_wcol = 0; m_en = 0; m_ie = 0;
    m_rate = 0; m_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s); #1;
      check("R1 reset reg", rd_data, 8'h00);
    end
    check("R1 reset outs", {irq, scl_hold, scl_tick, eng_en, eng_start, eng_stop}, 6'b0);
    rd_sel = 0;

    // R8: enable off with start/stop set -> they read 0
    wr(0, 8'h30);
    check("R8 off gate", rd_data, 8'h00);
    // R9: start and stop on, stop self-clears, start stays
    wr(0, 8'h34);
    check("R9 req set", rd_data, 8'h34);
    eng_stop_done = 1; cyc();
    check("R9 stop cleared", rd_data, 8'h24);
    repeat (3) cyc();
    check("R9 start stays", eng_start, 1'b1);
    wr(0, 8'h04);
    check("R9 start cleared by sw", eng_start, 1'b0);

    // R6: collision when flag clear
    rd_sel = 2;
    wr(2, 8'h5A);
    check("R6 data refused", rd_data, 8'h00);
    rd_sel = 0; #1;
    check("R6 wcol set", rd_data[3], 1'b1);
    wr(0, 8'h05);
    check("R6 wcol not writable", rd_data[3], 1'b1);

    // R2 / R4 / R5
    glb_irq_en = 1;
    eng_done = 1; cyc();
    check("R2 flag set", rd_data[7], 1'b1);
    check("R4 irq all on", irq, 1'b1);
    check("R5 hold on", scl_hold, 1'b1);
    glb_irq_en = 0; #1;
    check("R4 irq global off", irq, 1'b0);
    glb_irq_en = 1;
    wr(0, 8'h04);
    check("R3 write zero keeps flag", rd_data[7], 1'b1);
    check("R4 irq ie off", irq, 1'b0);
    seen = 0;
    for (int i = 0; i < 60; i++) begin cyc(); if (scl_tick) seen++; end
    check("R5 no ticks while held", seen, 0);
    // R6 accepted
    rd_sel = 2;
    wr(2, 8'hA5);
    check("R6 data accepted", rd_data, 8'hA5);
    rd_sel = 0; #1;
    check("R6 wcol cleared", rd_data[3], 1'b0);
    // R2 set beats clear in same cycle
    wr_en = 1; wr_sel = 0; wr_data = 8'h85; eng_done = 1; cyc();
    check("R2 set wins over clear", rd_data[7], 1'b1);
    wr(0, 8'h85);
    check("R3 write one clears", rd_data[7], 1'b0);

    // R10 rx load and bit 1
    eng_rx_load = 1; eng_rx_byte = 8'h3C; rd_sel = 2; cyc();
    check("R10 rx load", rd_data, 8'h3C);
    rd_sel = 0;
    wr(0, 8'h06);
    check("R10 bit1 zero", rd_data[1], 1'b0);

    // R7 tick periods
    wr(1, 8'd3);
    wr(0, 8'h00);
    wr(0, 8'h04);
    tick_gap(gap);
    check("R7 period rate3", gap, 22);
    wr(1, 8'd0);
    tick_gap(gap);
    check("R7 period rate0", gap, 16);
    wr(1, 8'd40);
    tick_gap(gap);
    check("R7 period rate40", gap, 96);
    wr(0, 8'h00);
    seen = 0;
    for (int i = 0; i < 120; i++) begin cyc(); if (scl_tick) seen++; end
    check("R7 no tick disabled", seen, 0);

    // mixed random stream
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] k;
      k = 3'($urandom_range(0, 7));
      wr_en = ($urandom_range(0, 2) == 0);
      wr_sel = 2'($urandom_range(0, 3));
      wr_data = 8'($urandom_range(0, 255));
      if (wr_sel == 0 && k != 0) wr_data[2] = 1'b1;
      if (wr_sel == 1) wr_data = 8'($urandom_range(0, 20));
      eng_done = ($urandom_range(0, 5) == 0);
      eng_stop_done = ($urandom_range(0, 4) == 0);
      eng_rx_load = ($urandom_range(0, 6) == 0);
      eng_rx_byte = 8'($urandom_range(0, 255));
      glb_irq_en = ($urandom_range(0, 3) != 0);
      rd_sel = 2'($urandom_range(0, 3));
      cyc();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule